// File: doc/BRIEF.md
# ATA PIO Register Access Sequencer

This block runs one register transaction at a time against an ATA/IDE device in programmed-I/O mode. A requester hands it a read or write, a 5-bit register select (address and chip-select lines together) and, for writes, a 16-bit data word. The sequencer then walks the device pins through a fixed, uninterruptible phase sequence: setup, strobe, recovery and hold. Each phase lasts for a cycle count that the requester programs. When the bus has been released, it returns a one-cycle completion pulse, which carries the captured word for reads.

The request port is a valid/ready handshake. `req_ready` is high only while the sequencer is idle and no device reset is being requested in the same cycle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a transaction or a device reset is in progress, `req_ready` stays low and any `req_valid` is ignored: it is neither queued nor remembered. The completion side has no back-pressure. `rsp_valid` is a single-cycle pulse that the requester must take when it occurs. The 16-bit device bus is split at the block edge into `ata_dout`, an output enable `ata_oe` and `ata_din`, and the pad ring combines them. A separate reset request holds the device reset line low for a programmed length. A device interrupt/status input is brought into the clock domain through a synchronizer.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, `req_ready`=1, `busy`=0, `rsp_valid`=0, `ata_rd_n`=`ata_wr_n`=`ata_rst_n`=1, `ata_oe`=0 and `ata_addr`=0 (the idle select value).
- R2: For a write with phase counts S, W, R and H, cycles are numbered from 1 starting with the cycle after acceptance. In cycles 1..S+W+R+H, `ata_oe`=1 and `ata_dout` equals the request data. In cycles 1..S+W+R, `ata_addr` shows the request address, and afterwards it shows 0. `ata_wr_n` is low exactly in cycles S+1..S+W.
- R3: A read uses the same phase timing with `ata_rd_n` low in cycles S+1..S+W. During a read, `ata_oe` stays 0. The word returned is the value on `ata_din` in cycle S+W, the last strobe-low cycle.
- R4: `rsp_valid` is high for exactly one cycle, cycle S+W+R+H+1. In that cycle `rsp_rdata` holds the read word.
- R5: A phase count or reset length of 0 acts as 1.
- R6: From acceptance through cycle S+W+R+H, `busy`=1 and `req_ready`=0. Requests presented in that window start no transaction, and no second strobe follows.
- R7: A device reset request taken while idle drives `ata_rst_n` low for L cycles (the programmed length). During those cycles both strobes stay high, `ata_oe`=0, `req_ready`=0, and register requests start nothing.
- R8: A device reset request has priority over a register request in the same idle cycle, so `req_ready` is 0 in that cycle. A reset request made during a transaction is ignored.
- R9: `dev_irq` follows `ata_irq` through two clock stages. A change appears after the second rising edge and not after the first.
- R10: The read and write strobes are never low together, and `ata_addr` does not change while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register select (address and chip-select lines) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, valid with rsp_valid |
| busy | output | 1 | Transaction or device reset in progress |
| dev_rst_req | input | 1 | Request a device reset pulse |
| cfg_setup | input | 8 | Address setup cycles |
| cfg_strobe | input | 8 | Strobe low cycles |
| cfg_recover | input | 8 | Strobe recovery cycles |
| cfg_hold | input | 8 | Data hold cycles after address removal |
| cfg_rst_len | input | 16 | Device reset low cycles |
| ata_addr | output | 5 | Device register select lines |
| ata_dout | output | 16 | Device data out |
| ata_oe | output | 1 | Device data output enable |
| ata_din | input | 16 | Device data in |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_rst_n | output | 1 | Active-low device reset |
| ata_irq | input | 1 | Device interrupt/status request (asynchronous) |
| dev_irq | output | 1 | Synchronized device interrupt/status |

## Verification
Properties that hold on every cycle are checked by the embedded assertions. These cover the mutual exclusion of the two strobes, address stability under a strobe, the output driver staying off during reads and device reset, completion following only the hold phase, and the latched request not changing during a transaction. The phase lengths, the exact cycle of completion, which edge captures read data, zero-count clamping, reset priority and the fact that requests made while busy leave no trace can only be shown by the bench's directed scenarios. Those scenarios count strobe, enable and address cycles against the programmed values.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_RECOVER = 3'd3,
    PH_HOLD    = 3'd4,
    PH_DEVRST  = 3'd5
  } ph_e;
endpackage

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  // a length of zero is clamped to one cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len == '0) |=> last);
endmodule

// File: rtl/ata_irq_sync.sv
module ata_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int TW        = 8,
  parameter int RW        = 16,
  parameter logic [AW-1:0] IDLE_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  input  logic          dev_rst_req,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic [TW-1:0] cfg_recover,
  input  logic [TW-1:0] cfg_hold,
  input  logic [RW-1:0] cfg_rst_len,
  output logic [AW-1:0] ata_addr,
  output logic [DW-1:0] ata_dout,
  output logic          ata_oe,
  input  logic [DW-1:0] ata_din,
  output logic          ata_rd_n,
  output logic          ata_wr_n,
  output logic          ata_rst_n
);
  ph_e           st;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  logic          tload;
  logic [RW-1:0] tlen;
  logic          tlast;

  ata_phase_timer #(.W(RW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tload),
    .len  (tlen),
    .last (tlast)
  );

  // timer reload at each phase entry
  always_comb begin
    tload = 1'b0;
    tlen  = '0;
    unique case (st)
      PH_IDLE: begin
        if (dev_rst_req) begin
          tload = 1'b1; tlen = cfg_rst_len;
        end else if (req_valid) begin
          tload = 1'b1; tlen = RW'(cfg_setup);
        end
      end
      PH_SETUP:   if (tlast) begin tload = 1'b1; tlen = RW'(cfg_strobe);  end
      PH_STROBE:  if (tlast) begin tload = 1'b1; tlen = RW'(cfg_recover); end
      PH_RECOVER: if (tlast) begin tload = 1'b1; tlen = RW'(cfg_hold);    end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (dev_rst_req) st <= PH_DEVRST;
          else if (req_valid) begin
            st      <= PH_SETUP;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        PH_SETUP:   if (tlast) st <= PH_STROBE;
        PH_STROBE: begin
          if (tlast) begin
            st <= PH_RECOVER;
            if (!wr_q) rdata_q <= ata_din;
          end
        end
        PH_RECOVER: if (tlast) st <= PH_HOLD;
        PH_HOLD: begin
          if (tlast) begin
            st     <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        PH_DEVRST:  if (tlast) st <= PH_IDLE;
        default:    st <= PH_IDLE;
      endcase
    end
  end

  logic addr_phase;
  logic xfer_phase;
  assign addr_phase = (st == PH_SETUP) || (st == PH_STROBE) || (st == PH_RECOVER);
  assign xfer_phase = addr_phase || (st == PH_HOLD);

  assign req_ready = (st == PH_IDLE) && !dev_rst_req;
  assign busy      = (st != PH_IDLE);
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;
  assign ata_addr  = addr_phase ? addr_q : IDLE_ADDR;
  assign ata_oe    = xfer_phase && wr_q;
  assign ata_dout  = ata_oe ? wdata_q : '0;
  assign ata_wr_n  = !((st == PH_STROBE) && wr_q);
  assign ata_rd_n  = !((st == PH_STROBE) && !wr_q);
  assign ata_rst_n = (st != PH_DEVRST);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> $stable(ata_addr));
  // R3
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !ata_oe);
  // R7
  devrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rst_n |-> (ata_rd_n && ata_wr_n && !ata_oe && !req_ready));
  // R4
  done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(st) == PH_HOLD && !busy));
  // R6
  req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_phase && $past(st) != PH_IDLE) |-> ($stable(addr_q) && $stable(wr_q)));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int RW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  input  logic          dev_rst_req,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic [TW-1:0] cfg_recover,
  input  logic [TW-1:0] cfg_hold,
  input  logic [RW-1:0] cfg_rst_len,
  output logic [AW-1:0] ata_addr,
  output logic [DW-1:0] ata_dout,
  output logic          ata_oe,
  input  logic [DW-1:0] ata_din,
  output logic          ata_rd_n,
  output logic          ata_wr_n,
  output logic          ata_rst_n,
  input  logic          ata_irq,
  output logic          dev_irq
);
  ata_pio_seq #(.AW(AW), .DW(DW), .TW(TW), .RW(RW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .busy       (busy),
    .dev_rst_req(dev_rst_req),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_recover(cfg_recover),
    .cfg_hold   (cfg_hold),
    .cfg_rst_len(cfg_rst_len),
    .ata_addr   (ata_addr),
    .ata_dout   (ata_dout),
    .ata_oe     (ata_oe),
    .ata_din    (ata_din),
    .ata_rd_n   (ata_rd_n),
    .ata_wr_n   (ata_wr_n),
    .ata_rst_n  (ata_rst_n)
  );

  ata_irq_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ata_irq),
    .dout (dev_irq)
  );
endmodule

// File: tb/tb_ata_pio_engine.sv
module tb_ata_pio_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, dev_rst_req = 1'b0, ata_irq = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, ata_din = '0;
  logic [7:0]  cfg_setup = 8'd1, cfg_strobe = 8'd1, cfg_recover = 8'd1, cfg_hold = 8'd1;
  logic [15:0] cfg_rst_len = 16'd1;
  logic        req_ready, rsp_valid, busy, ata_oe, ata_rd_n, ata_wr_n, ata_rst_n, dev_irq;
  logic [15:0] rsp_rdata, ata_dout;
  logic [4:0]  ata_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ata_pio_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .dev_rst_req(dev_rst_req), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_recover(cfg_recover), .cfg_hold(cfg_hold), .cfg_rst_len(cfg_rst_len),
    .ata_addr(ata_addr), .ata_dout(ata_dout), .ata_oe(ata_oe), .ata_din(ata_din),
    .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_rst_n(ata_rst_n),
    .ata_irq(ata_irq), .dev_irq(dev_irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // R1
  task automatic t_reset_state();
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(ata_rd_n && ata_wr_n && ata_rst_n, "R1", "strobes/reset high",
        {ata_rd_n, ata_wr_n, ata_rst_n}, 7);
    chk(ata_oe == 1'b0, "R1", "ata_oe", ata_oe, 0);
    chk(ata_addr == 5'd0, "R1", "ata_addr", ata_addr, 0);
  endtask

  // R2 R3 R4 R5 R6 R8: one transaction, phase cycles counted at the pins
  task automatic t_xfer(input bit wr, input logic [4:0] a, input logic [15:0] d,
                        input int s, input int w, input int r, input int h,
                        input logic [15:0] va, input logic [15:0] vb,
                        input bit poke, input string tag);
    int es = clamp1(s), ew = clamp1(w), er = clamp1(r), eh = clamp1(h);
    int total = es + ew + er + eh;
    int first_low = 0, low_cnt = 0, oe_cnt = 0, addr_cnt = 0, data_bad = 0;
    int other_low = 0, ready_bad = 0, rst_low = 0, done_at = 0, done_cnt = 0, late_low = 0;
    logic [15:0] rd_seen = '0;
    cfg_setup = s[7:0]; cfg_strobe = w[7:0]; cfg_recover = r[7:0]; cfg_hold = h[7:0];
    @(negedge clk);
    chk(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (poke) begin
      req_addr = 5'h1F; req_wdata = 16'hFFFF; req_write = ~wr; dev_rst_req = 1'b1;
    end else begin
      req_valid = 1'b0;
    end
    for (int cyc = 1; cyc <= total + 3; cyc++) begin
      if (rsp_valid) begin
        done_cnt++;
        if (done_at == 0) begin done_at = cyc; rd_seen = rsp_rdata; end
      end
      if (!(wr ? ata_wr_n : ata_rd_n)) begin
        if (first_low == 0) first_low = cyc;
        low_cnt++;
      end
      if (!(wr ? ata_rd_n : ata_wr_n)) other_low++;
      if (ata_oe) begin oe_cnt++; if (ata_dout != d) data_bad++; end
      if (ata_addr == a) addr_cnt++;
      if (!ata_rst_n) rst_low++;
      if (cyc <= total && (req_ready || !busy)) ready_bad++;
      ata_din = (cyc == es + ew) ? vb : va;
      if (cyc == total) begin req_valid = 1'b0; dev_rst_req = 1'b0; end
      @(negedge clk);
    end
    for (int k = 0; k < 12; k++) begin
      if (!ata_wr_n || !ata_rd_n) late_low++;
      if (!ata_rst_n) rst_low++;
      @(negedge clk);
    end
    chk(first_low == es + 1, "R2", {tag, " strobe start"}, first_low, es + 1);
    chk(low_cnt == ew, wr ? "R2" : "R3", {tag, " strobe width"}, low_cnt, ew);
    chk(other_low == 0, "R10", {tag, " wrong strobe"}, other_low, 0);
    chk(oe_cnt == (wr ? total : 0), wr ? "R2" : "R3", {tag, " oe cycles"}, oe_cnt, wr ? total : 0);
    chk(data_bad == 0, "R2", {tag, " dout value"}, data_bad, 0);
    chk(addr_cnt == es + ew + er, "R2", {tag, " addr cycles"}, addr_cnt, es + ew + er);
    chk(done_at == total + 1, "R4", {tag, " done cycle"}, done_at, total + 1);
    chk(done_cnt == 1, "R4", {tag, " done width"}, done_cnt, 1);
    chk(ready_bad == 0, "R6", {tag, " busy/ready"}, ready_bad, 0);
    chk(late_low == 0, "R6", {tag, " no extra transaction"}, late_low, 0);
    chk(rst_low == 0, "R8", {tag, " no device reset"}, rst_low, 0);
    if (!wr) chk(rd_seen == vb, "R3", {tag, " read word"}, rd_seen, vb);
    ata_din = '0;
  endtask

  // R7 R8 R5: device reset pulse with a competing register request
  task automatic t_devrst(input int len, input string tag);
    int el = clamp1(len);
    int rst_low = 0, bad = 0, late_low = 0;
    cfg_rst_len = len[15:0];
    @(negedge clk);
    dev_rst_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h07; req_wdata = 16'h1234;
    #1;
    chk(req_ready == 1'b0, "R8", {tag, " ready with reset request"}, req_ready, 0);
    @(negedge clk);
    dev_rst_req = 1'b0;
    for (int cyc = 1; cyc <= el + 2; cyc++) begin
      if (!ata_rst_n) rst_low++;
      if (cyc <= el && (!ata_wr_n || !ata_rd_n || ata_oe || req_ready)) bad++;
      if (cyc == el) req_valid = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 10; k++) begin
      if (!ata_wr_n || !ata_rd_n || !ata_rst_n) late_low++;
      @(negedge clk);
    end
    chk(rst_low == el, "R7", {tag, " reset low cycles"}, rst_low, el);
    chk(bad == 0, "R7", {tag, " quiet during reset"}, bad, 0);
    chk(late_low == 0, "R7", {tag, " blocked request"}, late_low, 0);
  endtask

  // R9
  task automatic t_irq();
    @(negedge clk);
    ata_irq = 1'b1;
    @(negedge clk);
    chk(dev_irq == 1'b0, "R9", "irq after one edge", dev_irq, 0);
    @(negedge clk);
    chk(dev_irq == 1'b1, "R9", "irq after two edges", dev_irq, 1);
    ata_irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dev_irq == 1'b0, "R9", "irq release", dev_irq, 0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_xfer(1'b1, 5'h0A, 16'hBEEF, 2, 3, 2, 1, 16'h0000, 16'h0000, 1'b0, "wr_a");
    t_xfer(1'b0, 5'h13, 16'h0000, 1, 4, 1, 2, 16'h1111, 16'hC0DE, 1'b0, "rd_a");
    t_xfer(1'b1, 5'h05, 16'h5A5A, 0, 0, 0, 0, 16'h0000, 16'h0000, 1'b0, "wr_zero_r5");
    t_xfer(1'b0, 5'h02, 16'h0000, 0, 1, 0, 0, 16'h2222, 16'h7E57, 1'b0, "rd_zero_r5");
    t_xfer(1'b1, 5'h11, 16'hA5C3, 3, 2, 1, 3, 16'h0000, 16'h0000, 1'b1, "wr_busy_r6");
    t_xfer(1'b0, 5'h0C, 16'h0000, 2, 2, 2, 2, 16'h3333, 16'h9876, 1'b1, "rd_busy_r6");
    t_devrst(5, "rst5");
    t_devrst(0, "rst0_r5");
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule